// File: doc/BRIEF.md
# Thirty-Column Frame Bit Interleaver

This block reorders one frame of bits or soft values through a matrix that always has thirty columns. The row count is the smallest that holds the frame. Samples arrive on a streaming input and are stored in a frame buffer. When the last sample of the frame has been stored, the buffer is read back in the new order as an unbroken stream that carries valid and last flags. A mode input chooses the transmit direction (interleave) or the receive direction (de-interleave). De-interleave is the exact inverse, so passing a frame through both directions returns it unchanged.

If the frame length is not a multiple of thirty, the unused cells at the end of the last row are treated as dummy cells. They are never placed on the output, so every output frame is exactly as long as its input frame. The frame length and the sample width are elaboration parameters. The frame length must be at least thirty.

Top module: `col30_interleaver`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1 and `out_valid` and `out_last` are 0.
- R2: In interleave mode (`mode_deint` = 0), input sample k fills matrix cell (row k/30, column k%30). The matrix has 30 columns and ceil(FRAME_LEN/30) rows.
- R3: In interleave mode, the output visits the columns in the order 0,20,10,5,15,25,3,13,23,8,18,28,1,11,21,6,16,26,4,14,24,19,9,29,12,2,7,22,27,17 and reads each column from the top row down.
- R4: Cells past the last input sample produce no output beat. A frame gives exactly FRAME_LEN output beats, and `out_last` is 1 on the last beat only.
- R5: In de-interleave mode (`mode_deint` = 1), input stream position j is put back at the matrix cell that interleave mode reads as its j-th output, and the output is read row-major. A frame that is interleaved and then de-interleaved comes back in its original order.
- R6: When FRAME_LEN is a multiple of 30, every column holds ROWS samples, so interleaved output beat j is input sample (j%ROWS)*30 + column(j/ROWS).
- R7: From the cycle after the last input sample is accepted, `in_ready` stays 0 for exactly FRAME_LEN cycles. During that time the output beats come in consecutive cycles, and `in_ready` returns to 1 together with the `out_last` beat.
- R8: The mode is taken from `mode_deint` on the first accepted sample of a frame. A change of `mode_deint` later in the same frame has no effect on that frame.
- R9: `in_valid` asserted while `in_ready` is 0 is ignored: no sample is stored and the next frame is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_deint | input | 1 | 0 = interleave, 1 = de-interleave; sampled on the first sample of a frame |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts input samples (frame loading phase) |
| in_data | input | W | Input sample |
| out_valid | output | 1 | Output beat present |
| out_data | output | W | Output sample |
| out_last | output | 1 | Final beat of the frame |

## Verification
The hardest case to reach from the ports is the short last row. There, some columns give one fewer beat than others, and the address walk must skip exactly the dummy cells in both directions. To reach it, one bench lane uses a length of 31, which leaves a single cell in the second row; lanes of 150 and 300 cover the case with no padding. A mode change in the middle of a frame and `in_valid` held high through the whole drain are driven on purpose. The next frame is then de-interleaved and compared with the original random data, which shows that neither stimulus was taken in.

// File: rtl/col30_pkg.sv
package col30_pkg;

  localparam int NCOLS = 30;

  typedef enum logic {
    PH_LOAD  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_e;

  // column visited at position idx of the read-out order
  function automatic logic [4:0] col_at(input logic [4:0] idx);
    logic [4:0] c;
    case (idx)
      5'd0:  c = 5'd0;   5'd1:  c = 5'd20;  5'd2:  c = 5'd10;
      5'd3:  c = 5'd5;   5'd4:  c = 5'd15;  5'd5:  c = 5'd25;
      5'd6:  c = 5'd3;   5'd7:  c = 5'd13;  5'd8:  c = 5'd23;
      5'd9:  c = 5'd8;   5'd10: c = 5'd18;  5'd11: c = 5'd28;
      5'd12: c = 5'd1;   5'd13: c = 5'd11;  5'd14: c = 5'd21;
      5'd15: c = 5'd6;   5'd16: c = 5'd16;  5'd17: c = 5'd26;
      5'd18: c = 5'd4;   5'd19: c = 5'd14;  5'd20: c = 5'd24;
      5'd21: c = 5'd19;  5'd22: c = 5'd9;   5'd23: c = 5'd29;
      5'd24: c = 5'd12;  5'd25: c = 5'd2;   5'd26: c = 5'd7;
      5'd27: c = 5'd22;  5'd28: c = 5'd27;  5'd29: c = 5'd17;
      default: c = 5'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/col30_addr_seq.sv
module col30_addr_seq
  import col30_pkg::*;
#(
  parameter int FRAME_LEN = 150,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  localparam int ROWS      = (FRAME_LEN + NCOLS - 1) / NCOLS;
  localparam int LAST_COLS = FRAME_LEN - (ROWS - 1) * NCOLS;
  localparam int ROW_W     = $clog2(ROWS + 1);
  localparam logic [5:0] LAST_COLS_W = 6'(LAST_COLS);

  logic [4:0]       ci;
  logic [ROW_W-1:0] row;
  logic [4:0]       col;
  logic             full_col;
  logic [ROW_W-1:0] bottom;

  // short last row: columns at or past LAST_COLS hold one row fewer
  always_comb begin
    col      = col_at(ci);
    full_col = ({1'b0, col} < LAST_COLS_W);
    bottom   = full_col ? ROW_W'(ROWS - 1) : ROW_W'(ROWS - 2);
    addr     = ADDR_W'(row) * ADDR_W'(NCOLS) + ADDR_W'(col);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ci  <= '0;
      row <= '0;
    end else if (step) begin
      if (row == bottom) begin
        row <= '0;
        ci  <= (ci == 5'd29) ? 5'd0 : ci + 5'd1;
      end else begin
        row <= row + 1'b1;
      end
    end
  end

  // R4: the walk never lands on a dummy cell
  a_r4_addr_in_frame: assert property (@(posedge clk) disable iff (rst)
    addr < ADDR_W'(FRAME_LEN));

endmodule

// File: rtl/col30_frame_ram.sv
module col30_frame_ram #(
  parameter int W      = 4,
  parameter int DEPTH  = 150,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [W-1:0]      wd,
  input  logic              re,
  input  logic [ADDR_W-1:0] ra,
  output logic [W-1:0]      rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rd <= mem[ra];
  end

  // R2: stores stay inside the matrix
  a_r2_write_in_range: assert property (@(posedge clk)
    we |-> wa < ADDR_W'(DEPTH));
  a_r2_read_in_range: assert property (@(posedge clk)
    re |-> ra < ADDR_W'(DEPTH));

endmodule

// File: rtl/col30_interleaver.sv
module col30_interleaver
  import col30_pkg::*;
#(
  parameter int FRAME_LEN = 150,
  parameter int W         = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_deint,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_last
);
  localparam int ROWS   = (FRAME_LEN + NCOLS - 1) / NCOLS;
  localparam int DEPTH  = ROWS * NCOLS;
  localparam int ADDR_W = $clog2(DEPTH);

  if (FRAME_LEN < NCOLS) begin : g_len_check
    $error("FRAME_LEN must be at least 30");
  end

  phase_e            phase;
  logic [ADDR_W-1:0] cnt;
  logic              mode_q;
  logic              wr_fire, at_end, mode_eff, rd_en;
  logic              seq_restart, seq_step;
  logic [ADDR_W-1:0] seq_addr, wr_addr, rd_addr;

  always_comb begin
    in_ready    = (phase == PH_LOAD);
    wr_fire     = in_valid && (phase == PH_LOAD);
    rd_en       = (phase == PH_DRAIN);
    at_end      = (cnt == ADDR_W'(FRAME_LEN - 1));
    mode_eff    = (cnt == '0) ? mode_deint : mode_q;
    seq_step    = wr_fire || rd_en;
    seq_restart = at_end && (wr_fire || rd_en);
    wr_addr     = mode_eff ? seq_addr : cnt;
    rd_addr     = mode_q ? cnt : seq_addr;
  end

  col30_addr_seq #(.FRAME_LEN(FRAME_LEN), .ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst(rst), .restart(seq_restart), .step(seq_step),
    .addr(seq_addr)
  );

  col30_frame_ram #(.W(W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) ram_i (
    .clk(clk), .we(wr_fire), .wa(wr_addr), .wd(in_data),
    .re(rd_en), .ra(rd_addr), .rd(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_LOAD;
      cnt       <= '0;
      mode_q    <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= rd_en;
      out_last  <= rd_en && at_end;
      if (phase == PH_LOAD) begin
        if (wr_fire) begin
          if (cnt == '0) mode_q <= mode_deint;
          if (at_end) begin
            cnt   <= '0;
            phase <= PH_DRAIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else begin
        if (at_end) begin
          cnt   <= '0;
          phase <= PH_LOAD;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // checker-only count of output beats in the current frame
  logic [ADDR_W-1:0] beat_cnt;
  always_ff @(posedge clk) begin
    if (rst || (out_valid && out_last)) beat_cnt <= '0;
    else if (out_valid)                 beat_cnt <= beat_cnt + 1'b1;
  end

  // R4: last flag only on a valid beat, and only on beat FRAME_LEN-1
  a_r4_last_is_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  a_r4_frame_beats: assert property (@(posedge clk) disable iff (rst)
    out_last |-> beat_cnt == ADDR_W'(FRAME_LEN - 1));
  // R7: output beats are back to back until the last one
  a_r7_no_gap: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);
  // R7: every busy cycle produces an output beat one cycle later
  a_r7_busy_feeds_out: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> out_valid);

endmodule

// File: tb/col30_lane.sv
module col30_lane #(
  parameter int LEN = 31,
  parameter int W   = 10
) (
  input  logic clk,
  input  logic rst,
  output logic done,
  output int   n_run,
  output int   n_fail
);
  localparam int ROWS = (LEN + 29) / 30;

  logic         mode_deint, in_valid, in_ready, out_valid, out_last;
  logic [W-1:0] in_data, out_data;

  col30_interleaver #(.FRAME_LEN(LEN), .W(W)) dut_i (
    .clk(clk), .rst(rst), .mode_deint(mode_deint),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  int perm [30] = '{0,20,10,5,15,25,3,13,23,8,18,28,1,11,21,
                    6,16,26,4,14,24,19,9,29,12,2,7,22,27,17};
  int           rd_map [LEN];
  logic [W-1:0] src [LEN];
  logic [W-1:0] exp_q [LEN];
  logic [W-1:0] orig [LEN];
  logic [W-1:0] got [LEN];
  logic         glast [LEN];
  int gcnt, busy, cyc, first_cyc, last_cyc;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!in_ready) busy++;
      if (out_valid) begin
        if (gcnt < LEN) begin
          got[gcnt]   = out_data;
          glast[gcnt] = out_last;
        end
        if (gcnt == 0) first_cyc = cyc;
        last_cyc = cyc;
        gcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s len=%0d %s: actual %0d expected %0d", tag, LEN, what, act, expv);
    end
  endtask

  task automatic run_frame(input bit mode, input bit flip, input bit junk, input string tag);
    gcnt = 0;
    busy = 0;
    for (int k = 0; k < LEN; k++) begin
      @(negedge clk);
      in_valid   = 1'b1;
      in_data    = src[k];
      mode_deint = (flip && k > 0) ? ~mode : mode;
    end
    @(negedge clk);
    in_valid   = junk;
    in_data    = W'($urandom);
    mode_deint = ~mode;
    for (int k = 0; k < LEN - 1; k++) begin
      @(negedge clk);
      in_data = W'($urandom);
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    // R4: exact beat count; R7: busy window and contiguity
    chk(gcnt == LEN, "R4", "output beat count", gcnt, LEN);
    chk(busy == LEN, "R7", "in_ready low cycles", busy, LEN);
    chk(last_cyc - first_cyc == LEN - 1, "R7", "output span", last_cyc - first_cyc, LEN - 1);
    chk(in_ready == 1'b1, "R7", "in_ready after frame", int'(in_ready), 1);
    for (int j = 0; j < LEN; j++) begin
      chk(got[j] == exp_q[j], tag, $sformatf("data beat %0d", j), int'(got[j]), int'(exp_q[j]));
      chk(glast[j] == (j == LEN - 1), "R4", $sformatf("last flag beat %0d", j),
          int'(glast[j]), int'(j == LEN - 1));
    end
  endtask

  initial begin
    int j;
    done = 1'b0; n_run = 0; n_fail = 0;
    gcnt = 0; busy = 0; cyc = 0; first_cyc = 0; last_cyc = 0;
    in_valid = 1'b0; in_data = '0; mode_deint = 1'b0;
    j = 0;
    for (int ci = 0; ci < 30; ci++)
      for (int r = 0; r < ROWS; r++)
        if (r * 30 + perm[ci] < LEN) begin
          rd_map[j] = r * 30 + perm[ci];
          j++;
        end

    @(negedge clk);
    while (rst) @(negedge clk);
    // R1: idle state after reset
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(out_last == 1'b0, "R1", "out_last after reset", int'(out_last), 0);

    // R2 R3 R4: interleave a ramp; each beat names its source cell
    for (int k = 0; k < LEN; k++) src[k] = W'(k);
    for (int q = 0; q < LEN; q++) exp_q[q] = W'(rd_map[q]);
    run_frame(1'b0, 1'b0, 1'b0, "R2 R3 R4");
    if (LEN % 30 == 0)
      for (int q = 0; q < LEN; q++)
        chk(got[q] == W'((q % ROWS) * 30 + perm[q / ROWS]), "R6",
            $sformatf("unpadded beat %0d", q), int'(got[q]), (q % ROWS) * 30 + perm[q / ROWS]);

    // R5: de-interleave the interleaved ramp back into order
    for (int q = 0; q < LEN; q++) src[q] = W'(rd_map[q]);
    for (int k = 0; k < LEN; k++) exp_q[k] = W'(k);
    run_frame(1'b1, 1'b0, 1'b0, "R5");

    // R8 R9: random frame, mode flipped mid-frame, in_valid held during drain
    for (int k = 0; k < LEN; k++) begin
      orig[k] = W'($urandom);
      src[k]  = orig[k];
    end
    for (int q = 0; q < LEN; q++) exp_q[q] = orig[rd_map[q]];
    run_frame(1'b0, 1'b1, 1'b1, "R8");

    // R5 R9: round trip of the random frame after the ignored drain input
    for (int q = 0; q < LEN; q++) src[q] = got[q];
    for (int k = 0; k < LEN; k++) exp_q[k] = orig[k];
    run_frame(1'b1, 1'b0, 1'b1, "R5 R9");

    done = 1'b1;
  end

endmodule

// File: tb/col30_interleaver_tb_top.sv
module col30_interleaver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic d31, d150, d300;
  int   r31, r150, r300, f31, f150, f300;

  col30_lane #(.LEN(31),  .W(10)) lane_31  (.clk(clk), .rst(rst), .done(d31),  .n_run(r31),  .n_fail(f31));
  col30_lane #(.LEN(150), .W(10)) lane_150 (.clk(clk), .rst(rst), .done(d150), .n_run(r150), .n_fail(f150));
  col30_lane #(.LEN(300), .W(10)) lane_300 (.clk(clk), .rst(rst), .done(d300), .n_run(r300), .n_fail(f300));

  initial begin
    int waited;
    int runs;
    int fails;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    waited = 0;
    while (!(d31 && d150 && d300) && waited < WATCHDOG) begin
      @(negedge clk);
      waited++;
    end
    runs  = r31 + r150 + r300;
    fails = f31 + f150 + f300;
    if (!(d31 && d150 && d300)) begin
      runs++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", waited);
    end
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule